// File: doc/BRIEF.md
# Flash Byte Program and Chip Erase Sequencer

This block is a clocked bus master for an asynchronous, byte-wide parallel flash device. It drives the address bus, the write data and the three active-low strobes (chip select, read strobe, write strobe). When asked to program a byte, it issues an unlock-prefixed command sequence with write strobe timing enforced in clock cycles. It then reads the target location until bit 7 of the returned data matches the expected value. It reports completion with a one-cycle `done` pulse. If the device does not complete within a fixed number of polling reads, it reports a timeout instead. A second request performs the six-write chip erase, which is polled in the same way.

Every timing figure is a nanosecond minimum parameter, converted to whole clock cycles by rounding up. The write low phase uses the largest of three figures: the strobe width, the address hold after the falling edge, and the data setup before the rising edge. The tristate pad is outside the block. The block provides the outgoing byte and a drive enable, and takes back only bit 7 of the bus.

The controller has seven states. In IDLE it waits for a request and takes a snapshot of the address and data. WR_SETUP presents the address and data with the write strobe high. WR_PULSE holds the write strobe low. WR_RECOV holds the write strobe high again. It then goes back to WR_SETUP for the next command, or on to POLL_READ after the last one. POLL_READ holds the read strobe low for the access time and samples bit 7 on its final cycle. From there it goes to DONE on a match or when the poll limit is reached, and to POLL_GAP otherwise. POLL_GAP keeps the read strobe high before the next read. DONE emits the completion pulse and returns to IDLE.

Top module: `flash_byte_programmer`

## Requirements
- R1: A program request issues exactly four writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the captured data byte to the captured address.
- R2: An erase request issues exactly six writes, in this order: 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, 0x10/0x5555.
- R3: Each write strobe low phase lasts at least the rounded-up maximum of the strobe width, the address hold and the data setup minimums (20 cycles at the defaults and a 10 ns clock). During that phase, chip select is low and the address and data do not change.
- R4: Between two consecutive writes, the write strobe stays high for at least the rounded-up recovery minimum (20 cycles at the defaults).
- R5: The read strobe is high whenever the write strobe is low, and the data drive enable is low whenever the read strobe is low.
- R6: After the last write, the block reads the programmed address (address 0 for erase). Completion is when bit 7 equals the written data's bit 7 (1 for erase). The number of reads is one more than the number of reads on which the device reported busy.
- R7: Between two polling reads, the read strobe is high for at least the rounded-up gap minimum (15 cycles at the defaults).
- R8: `done` is a one-cycle pulse at the end of every operation. `busy` is high from the cycle after a request is accepted until the cycle after `done`.
- R9: If `TIMEOUT_POLLS` reads all fail, the block stops after the last of them and raises `timeout_err` with `done`. The flag stays set until the next request is accepted, which clears it.
- R10: A request that arrives while `busy` is high has no effect. If both requests arrive in the same idle cycle, the program request wins.
- R11: After reset, all three strobes are high, and the drive enable, `busy`, `done` and `timeout_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prog | input | 1 | Request a byte program (sampled in IDLE) |
| start_erase | input | 1 | Request a chip erase (sampled in IDLE) |
| prog_addr | input | ADDR_W | Byte address to program |
| prog_data | input | DATA_W | Byte value to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last operation ended by poll limit |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | DATA_W | Byte to drive onto the flash data bus |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_q7_in | input | 1 | Bit 7 of the flash data bus |
| flash_ce_n | output | 1 | Chip select, active low |
| flash_oe_n | output | 1 | Read strobe, active low |
| flash_we_n | output | 1 | Write strobe, active low |

## Verification
The assertions check the bus timing rules on every cycle:
- the minimum widths of the strobe low phase, the strobe recovery and the read gap;
- the address and data staying stable while the strobe is low;
- the write and read strobes never overlapping;
- no drive onto the bus during a read;
- the single-cycle `done` and the clearing of the error flag.

Only the bench scenarios can show the rest. These are the exact command bytes and addresses and their order for each request, the number of polling reads against a device model with a chosen busy latency, the timeout boundary, and request priority and rejection while busy.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_PULSE  = 3'd2,
        ST_WR_RECOV  = 3'd3,
        ST_POLL_READ = 3'd4,
        ST_POLL_GAP  = 3'd5,
        ST_DONE      = 3'd6
    } fstate_t;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } fop_t;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_prog_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  fop_t              op,
    input  logic [2:0]        idx,
    input  logic [ADDR_W-1:0] user_addr,
    input  logic [DATA_W-1:0] user_data,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_last
);
    localparam logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'(17'h05555);
    localparam logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'(17'h02AAA);
    localparam logic [DATA_W-1:0] KEY_1    = DATA_W'(8'hAA);
    localparam logic [DATA_W-1:0] KEY_2    = DATA_W'(8'h55);
    localparam logic [DATA_W-1:0] CMD_PROG = DATA_W'(8'hA0);
    localparam logic [DATA_W-1:0] CMD_ERS1 = DATA_W'(8'h80);
    localparam logic [DATA_W-1:0] CMD_ERS2 = DATA_W'(8'h10);

    always_comb begin
        cmd_addr = UNLOCK_A;
        cmd_data = KEY_1;
        unique case (idx)
            3'd0: begin cmd_addr = UNLOCK_A; cmd_data = KEY_1; end
            3'd1: begin cmd_addr = UNLOCK_B; cmd_data = KEY_2; end
            3'd2: begin
                cmd_addr = UNLOCK_A;
                cmd_data = (op == OP_PROG) ? CMD_PROG : CMD_ERS1;
            end
            3'd3: begin
                cmd_addr = (op == OP_PROG) ? user_addr : UNLOCK_A;
                cmd_data = (op == OP_PROG) ? user_data : KEY_1;
            end
            3'd4: begin cmd_addr = UNLOCK_B; cmd_data = KEY_2; end
            3'd5: begin cmd_addr = UNLOCK_A; cmd_data = CMD_ERS2; end
            default: begin cmd_addr = UNLOCK_A; cmd_data = KEY_1; end
        endcase
    end

    assign cmd_last = (op == OP_PROG) ? (idx == 3'd3) : (idx == 3'd5);

endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flash_poll_counter.sv
module flash_poll_counter #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int unsigned PW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [PW-1:0] LAST = PW'(LIMIT - 1);

    logic [PW-1:0] fails;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fails <= '0;
        end else if (clr) begin
            fails <= '0;
        end else if (inc && fails != LAST) begin
            fails <= fails + 1'b1;
        end
    end

    assign at_last = (fails == LAST);

endmodule

// File: rtl/flash_byte_programmer.sv
module flash_byte_programmer
    import flash_prog_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_NS        = 10,
    parameter int unsigned SETUP_NS      = 10,
    parameter int unsigned WE_LOW_NS     = 200,
    parameter int unsigned WE_HIGH_NS    = 200,
    parameter int unsigned ADDR_HOLD_NS  = 100,
    parameter int unsigned DATA_SETUP_NS = 100,
    parameter int unsigned READ_ACC_NS   = 55,
    parameter int unsigned POLL_GAP_NS   = 150,
    parameter int unsigned TIMEOUT_POLLS = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dq_out,
    output logic              flash_dq_oe,
    input  logic              flash_q7_in,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n
);
    // Phase lengths in clock cycles, rounded up from the nanosecond minimums.
    localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
    localparam int unsigned PULSE_CYC = max2(ns_to_cyc(WE_LOW_NS, CLK_NS),
                                             max2(ns_to_cyc(ADDR_HOLD_NS, CLK_NS),
                                                  ns_to_cyc(DATA_SETUP_NS, CLK_NS)));
    localparam int unsigned RECOV_CYC = ns_to_cyc(WE_HIGH_NS, CLK_NS);
    localparam int unsigned ACC_CYC   = ns_to_cyc(READ_ACC_NS, CLK_NS);
    localparam int unsigned GAP_CYC   = ns_to_cyc(POLL_GAP_NS, CLK_NS);
    localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC),
                                             max2(RECOV_CYC, max2(ACC_CYC, GAP_CYC)));
    localparam int unsigned TW        = $clog2(MAX_CYC + 1) + 1;

    fstate_t           state_q, state_d;
    fop_t              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        idx_q;
    logic              err_q;

    logic [TW-1:0]     phase_cnt;
    logic [TW-1:0]     phase_len;
    logic              phase_end;
    logic              phase_clr;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;

    logic              accept_prog;
    logic              accept_erase;
    logic              accept;
    logic              poll_match;
    logic              poll_at_last;
    logic              poll_fail;
    logic              set_err;
    logic              expect_q7;
    logic [ADDR_W-1:0] poll_addr;

    // Request acceptance: only in IDLE, program has priority.
    assign accept_prog  = (state_q == ST_IDLE) && start_prog;
    assign accept_erase = (state_q == ST_IDLE) && !start_prog && start_erase;
    assign accept       = accept_prog || accept_erase;

    assign expect_q7  = (op_q == OP_ERASE) ? 1'b1 : data_q[DATA_W-1];
    assign poll_addr  = (op_q == OP_ERASE) ? '0 : addr_q;
    assign poll_match = (flash_q7_in == expect_q7);
    assign poll_fail  = (state_q == ST_POLL_READ) && phase_end && !poll_match;
    assign set_err    = poll_fail && poll_at_last;

    flash_cmd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmd_seq (
        .op        (op_q),
        .idx       (idx_q),
        .user_addr (addr_q),
        .user_data (data_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_last  (cmd_last)
    );

    flash_phase_timer #(
        .CNT_W (TW)
    ) u_phase_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .cnt   (phase_cnt)
    );

    flash_poll_counter #(
        .LIMIT (TIMEOUT_POLLS)
    ) u_poll_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (poll_fail),
        .at_last (poll_at_last)
    );

    // Length of the current phase.
    always_comb begin
        unique case (state_q)
            ST_WR_SETUP:  phase_len = TW'(SETUP_CYC);
            ST_WR_PULSE:  phase_len = TW'(PULSE_CYC);
            ST_WR_RECOV:  phase_len = TW'(RECOV_CYC);
            ST_POLL_READ: phase_len = TW'(ACC_CYC);
            ST_POLL_GAP:  phase_len = TW'(GAP_CYC);
            default:      phase_len = TW'(1);
        endcase
    end

    assign phase_end = (phase_cnt == phase_len - 1'b1);
    assign phase_clr = (state_d != state_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                if (phase_end) state_d = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (phase_end) state_d = ST_WR_RECOV;
            end
            ST_WR_RECOV: begin
                if (phase_end) state_d = cmd_last ? ST_POLL_READ : ST_WR_SETUP;
            end
            ST_POLL_READ: begin
                if (phase_end) begin
                    if (poll_match || poll_at_last) state_d = ST_DONE;
                    else                            state_d = ST_POLL_GAP;
                end
            end
            ST_POLL_GAP: begin
                if (phase_end) state_d = ST_POLL_READ;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and operation context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= accept_prog ? OP_PROG : OP_ERASE;
                addr_q <= prog_addr;
                data_q <= prog_data;
                idx_q  <= '0;
                err_q  <= 1'b0;
            end else begin
                if (state_q == ST_WR_RECOV && phase_end && !cmd_last) begin
                    idx_q <= idx_q + 1'b1;
                end
                if (set_err) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // Bus and status outputs, decoded from the state.
    always_comb begin
        flash_ce_n   = 1'b1;
        flash_oe_n   = 1'b1;
        flash_we_n   = 1'b1;
        flash_dq_oe  = 1'b0;
        flash_addr   = '0;
        flash_dq_out = '0;
        done         = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_WR_SETUP, ST_WR_RECOV: begin
                flash_ce_n   = 1'b0;
                flash_dq_oe  = 1'b1;
                flash_addr   = cmd_addr;
                flash_dq_out = cmd_data;
            end
            ST_WR_PULSE: begin
                flash_ce_n   = 1'b0;
                flash_we_n   = 1'b0;
                flash_dq_oe  = 1'b1;
                flash_addr   = cmd_addr;
                flash_dq_out = cmd_data;
            end
            ST_POLL_READ: begin
                flash_ce_n = 1'b0;
                flash_oe_n = 1'b0;
                flash_addr = poll_addr;
            end
            ST_POLL_GAP: begin
                flash_ce_n = 1'b0;
                flash_addr = poll_addr;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign timeout_err = err_q;

    // Run-length counters used only by the assertions below.
    logic [15:0] we_lo_run, we_hi_run, oe_hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_run <= '0;
            we_hi_run <= 16'hFFFF;
            oe_hi_run <= 16'hFFFF;
        end else begin
            we_lo_run <= flash_we_n  ? '0 : ((we_lo_run == 16'hFFFF) ? we_lo_run : we_lo_run + 1'b1);
            we_hi_run <= !flash_we_n ? '0 : ((we_hi_run == 16'hFFFF) ? we_hi_run : we_hi_run + 1'b1);
            oe_hi_run <= !flash_oe_n ? '0 : ((oe_hi_run == 16'hFFFF) ? oe_hi_run : oe_hi_run + 1'b1);
        end
    end

    AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (we_lo_run >= 16'(PULSE_CYC))); // R3
    AST_CE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> !flash_ce_n); // R3
    AST_BUS_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out))); // R3
    AST_WE_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> (we_hi_run >= 16'(RECOV_CYC))); // R4
    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> flash_oe_n); // R5
    AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_dq_oe); // R5
    AST_POLL_GAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_oe_n) |-> (oe_hi_run >= 16'(GAP_CYC))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ERR_CLEAR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !timeout_err); // R9

endmodule

// File: tb/test_flash_byte_programmer.sv
`timescale 1ns/1ps
module test_flash_byte_programmer;

    localparam int unsigned AW      = 17;
    localparam int unsigned DW      = 8;
    localparam int unsigned TMO     = 40;
    localparam int unsigned PULSE_C = 20;
    localparam int unsigned RECOV_C = 20;
    localparam int unsigned GAP_C   = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_prog = 1'b0;
    logic          start_erase = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [DW-1:0] prog_data = '0;
    logic          busy, done, timeout_err;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq_out;
    logic          flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n;
    logic          flash_q7_in;

    always #5 clk = ~clk;

    flash_byte_programmer #(
        .ADDR_W (AW), .DATA_W (DW), .TIMEOUT_POLLS (TMO)
    ) i_flash_byte_programmer (
        .clk (clk), .rst_n (rst_n),
        .start_prog (start_prog), .start_erase (start_erase),
        .prog_addr (prog_addr), .prog_data (prog_data),
        .busy (busy), .done (done), .timeout_err (timeout_err),
        .flash_addr (flash_addr), .flash_dq_out (flash_dq_out),
        .flash_dq_oe (flash_dq_oe), .flash_q7_in (flash_q7_in),
        .flash_ce_n (flash_ce_n), .flash_oe_n (flash_oe_n), .flash_we_n (flash_we_n)
    );

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;

    // Device model and bus monitor state.
    logic [DW-1:0] exp_byte = 8'hFF;
    int unsigned   polls_left = 0;
    logic [AW-1:0] rd_exp_addr = '0;
    logic [AW-1:0] wr_addr [8];
    logic [DW-1:0] wr_data [8];
    int unsigned   wr_n = 0, rd_n = 0;
    int unsigned   we_lo = 0, we_hi = 1000, oe_hi = 1000;
    int unsigned   pulse_bad = 0, recov_bad = 0, overlap_bad = 0, gap_bad = 0, raddr_bad = 0, stab_bad = 0;
    logic          we_prev = 1'b1, oe_prev = 1'b1;
    logic [AW-1:0] a_prev = '0;
    logic [DW-1:0] d_prev = '0;

    assign flash_q7_in = (polls_left == 0) ? exp_byte[7] : ~exp_byte[7];

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_prev && flash_we_n) begin
                if (wr_n < 8) begin
                    wr_addr[wr_n] = flash_addr;
                    wr_data[wr_n] = flash_dq_out;
                end
                wr_n++;
                if (we_lo < PULSE_C) pulse_bad++;
            end
            if (we_prev && !flash_we_n && we_hi < RECOV_C) recov_bad++;
            if (!we_prev && !flash_we_n && (flash_addr != a_prev || flash_dq_out != d_prev)) stab_bad++;
            if (!flash_we_n && (!flash_oe_n || flash_ce_n)) overlap_bad++;
            if (!flash_oe_n && flash_dq_oe) overlap_bad++;
            if (!flash_oe_n && flash_addr != rd_exp_addr) raddr_bad++;
            if (oe_prev && !flash_oe_n && oe_hi < GAP_C) gap_bad++;
            if (!oe_prev && flash_oe_n) begin
                rd_n++;
                if (polls_left > 0) polls_left--;
            end
            we_lo = flash_we_n ? 0 : we_lo + 1;
            we_hi = flash_we_n ? we_hi + 1 : 0;
            oe_hi = flash_oe_n ? oe_hi + 1 : 0;
            we_prev = flash_we_n;
            oe_prev = flash_oe_n;
            a_prev  = flash_addr;
            d_prev  = flash_dq_out;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected command write i for a program (erase=0) or an erase (erase=1).
    function automatic logic [AW+DW-1:0] exp_write(input bit erase, input int i,
                                                   input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        case (i)
            0: begin ea = 17'h05555; ed = 8'hAA; end
            1: begin ea = 17'h02AAA; ed = 8'h55; end
            2: begin ea = 17'h05555; ed = erase ? 8'h80 : 8'hA0; end
            3: begin ea = erase ? 17'h05555 : a; ed = erase ? 8'hAA : d; end
            4: begin ea = 17'h02AAA; ed = 8'h55; end
            default: begin ea = 17'h05555; ed = 8'h10; end
        endcase
        return {ea, ed};
    endfunction

    function automatic int unsigned exp_reads(input int unsigned latency);
        return (latency >= TMO) ? TMO : latency + 1;
    endfunction

    task automatic run_op(input bit erase, input bit both, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int unsigned latency, input bit poke_busy);
        string rq;
        bit    got;
        int unsigned nw;
        rq = erase ? "R2" : "R1";
        exp_byte    = erase ? 8'hFF : d;
        rd_exp_addr = erase ? '0 : a;
        polls_left  = latency;
        wr_n = 0; rd_n = 0;
        pulse_bad = 0; recov_bad = 0; overlap_bad = 0; gap_bad = 0; raddr_bad = 0; stab_bad = 0;
        @(negedge clk);
        prog_addr   = a;
        prog_data   = d;
        start_prog  = !erase || both;
        start_erase = erase || both;
        @(negedge clk);
        start_prog = 1'b0; start_erase = 1'b0;
        prog_addr = ~a; prog_data = ~d;
        check("R8", "busy after request", busy, 1);
        check("R9", "err cleared on accept", timeout_err, 0);
        got = 0;
        for (int c = 0; c < 20000; c++) begin
            if (poke_busy && c == 30) begin start_erase = 1'b1; start_prog = 1'b1; end
            if (poke_busy && c == 31) begin start_erase = 1'b0; start_prog = 1'b0; end
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check("R8", "done seen", got, 1);
        check("R9", "timeout flag with done", timeout_err, latency >= TMO);
        @(negedge clk);
        check("R8", "done single cycle", done, 0);
        check("R8", "busy cleared after done", busy, 0);
        nw = (erase && !both) ? 6 : 4;
        check(both ? "R10" : rq, "write count", wr_n, nw);
        for (int i = 0; i < int'(nw); i++) begin
            if (i < int'(wr_n))
                check(rq, $sformatf("write %0d addr/data", i), {wr_addr[i], wr_data[i]},
                      exp_write(erase && !both, i, a, d));
        end
        check("R3", "strobe low width", pulse_bad, 0);
        check("R3", "bus stable in pulse", stab_bad, 0);
        check("R4", "strobe recovery", recov_bad, 0);
        check("R5", "strobe overlap/drive", overlap_bad, 0);
        check("R6", "poll address", raddr_bad, 0);
        check("R6", "poll read count", rd_n, exp_reads(latency));
        check("R7", "poll gap", gap_bad, 0);
        check("R9", "timeout flag held", timeout_err, latency >= TMO);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check("R11", "ce_n reset", flash_ce_n, 1);
        check("R11", "oe_n reset", flash_oe_n, 1);
        check("R11", "we_n reset", flash_we_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "dq_oe/busy/done/err idle", {flash_dq_oe, busy, done, timeout_err}, 0);
        // Directed corners.
        run_op(0, 0, 17'h1ABCD, 8'h80, 0, 0);     // R6 immediate completion, bit7=1
        run_op(0, 0, 17'h00000, 8'h3C, 5, 0);     // R6 bit7=0
        run_op(1, 0, '0, '0, 7, 0);               // R2 erase
        run_op(0, 0, 17'h12345, 8'hC3, TMO - 1, 0); // R9 succeeds on last allowed read
        run_op(0, 0, 17'h0FFFF, 8'h01, 1000, 0);  // R9 timeout
        repeat (5) @(negedge clk);
        check("R9", "flag held in idle", timeout_err, 1);
        run_op(0, 1, 17'h00777, 8'h5A, 2, 0);     // R10 both requests: program wins
        run_op(0, 0, 17'h1F00F, 8'hA5, 9, 1);     // R10 requests while busy ignored
        run_op(1, 0, '0, '0, TMO, 1);             // R9 erase timeout, R10 poke
        // Random operations.
        for (int k = 0; k < 10; k++) begin
            run_op(bit'($urandom % 4 == 0), 0, AW'($urandom), DW'($urandom), $urandom % 30, 0);
        end
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule